// File: doc/BRIEF.md
# Command Post Queue Register Block

This block sits on the controller side of a host/storage-controller link and exposes a small memory-mapped register window. The host posts 32-bit command addresses by writing them to an inbound queue register. The controller drains that queue through a FIFO-style pop port. In the other direction, the controller pushes completed command tags into an outbound queue. The host collects them by reading the outbound queue register. A read of the outbound queue when it holds nothing returns an all-ones marker.

Interrupt status is built from two sources: the outbound queue holding at least one entry, and a pending outbound doorbell that the controller raises. Each source has a mask bit. A parameter places the "queue has entries" status bit at bit 3, at bit 2, or at both, to match two board variants. The host can also ring an inbound doorbell, which sends a one-cycle pulse to the controller to say that its configuration table has changed. Queue entries pass through the block unchanged. The low two bits of an entry carry a fetch-size code on the way in and an error flag (bit 1) on the way out.

Top module: `cmdq_regs`

## Requirements
- R1: A write to offset 0x40 appends all 32 bits of the write data, low bits included, to the inbound queue. `in_avail` is high while that queue holds entries, `in_data` shows the oldest entry, and `in_pop` removes it, so entries leave in the order they were written.
- R2: A read at offset 0x44 returns the oldest outbound entry on `reg_rdata` one cycle after the read strobe and removes that entry. When the outbound queue is empty, the read returns 0xFFFFFFFF and changes nothing.
- R3: Outbound entries come back bit-exact, including an error flag in bit 1.
- R4: The status register at 0x30 holds the doorbell-pending flag in bit 0. It holds the "outbound queue has entries" flag at bit 3 when NE_MODE=0, at bit 2 when NE_MODE=1, and at both bits when NE_MODE=2. All other bits read 0. The mask register at 0x34 is readable and writable.
- R5: `irq` is high exactly when some status bit is set and its mask bit is clear. It follows state with no extra register, so it falls in the cycle right after the clock edge that pops the last outbound entry.
- R6: A write to 0x20 with bit 0 set makes `cfg_pulse` high for exactly the one cycle after the write. A write with bit 0 clear makes no pulse.
- R7: `db_set` sets the doorbell-pending flag, which reads back in bit 0 of offset 0x9C. A write to 0xA0 with bit 0 set clears the flag, and a write with bit 0 clear leaves it unchanged. When `db_set` and the clearing write arrive in the same cycle, `db_set` wins.
- R8: A write to the inbound queue while it is full is dropped. It also sets a sticky overflow flag, which reads in bit 0 of offset 0x48 and is cleared only by reset.
- R9: Reads of unmapped or write-only offsets (0x20, 0x40, 0xA0) return 0. Writes to unmapped or read-only offsets are ignored.
- R10: Reset empties both queues and clears the mask, the doorbell-pending flag, the overflow flag and `cfg_pulse`.
- R11: `out_full` is high when the outbound queue holds DEPTH entries. A push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | ADDR_W | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| in_avail | output | 1 | Inbound queue holds an entry |
| in_data | output | 32 | Oldest inbound entry |
| in_pop | input | 1 | Controller removes the oldest inbound entry |
| out_push | input | 1 | Controller appends a completion tag |
| out_data | input | 32 | Completion tag to append |
| out_full | output | 1 | Outbound queue is full |
| cfg_pulse | output | 1 | One-cycle configuration-change pulse |
| db_set | input | 1 | Controller raises the outbound doorbell |
| irq | output | 1 | Unmasked interrupt request |

## Verification
The assertions assume that read and write strobes carry a stable offset and data in the cycle they are high. They also assume that `in_pop` and `out_push` are plain single-cycle requests, which the block may ignore on an empty or full queue. The bench drives every input half a cycle away from the active edge and holds each strobe for exactly one cycle. It only pushes past a full queue or pops an empty one on purpose, in the tests that cover dropped requests.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   // Register offsets; host software decodes these, so they are fixed.
   localparam logic [7:0] OFS_DOORBELL = 8'h20;
   localparam logic [7:0] OFS_ISR      = 8'h30;
   localparam logic [7:0] OFS_IMR      = 8'h34;
   localparam logic [7:0] OFS_INQ      = 8'h40;
   localparam logic [7:0] OFS_OUTQ     = 8'h44;
   localparam logic [7:0] OFS_OVF      = 8'h48;
   localparam logic [7:0] OFS_OSTAT    = 8'h9C;
   localparam logic [7:0] OFS_OCLR     = 8'hA0;

   localparam logic [31:0] EMPTY_TAG = 32'hFFFF_FFFF;

   // Placement of the "outbound queue has entries" status bit.
   localparam int NE_AT_BIT3 = 0;
   localparam int NE_AT_BIT2 = 1;
   localparam int NE_AT_BOTH = 2;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("cmdq_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq
   import cmdq_pkg::*;
#(
   parameter int NE_MODE = NE_AT_BIT3
) (
   input  logic        ob_has_entry,
   input  logic        db_pending,
   input  logic [31:0] imr,
   output logic [31:0] isr,
   output logic        irq
);
   if (NE_MODE < NE_AT_BIT3 || NE_MODE > NE_AT_BOTH) begin : g_bad_mode
      $error("cmdq_irq: NE_MODE out of range");
   end

   logic [31:0] ne_bits;

   if (NE_MODE == NE_AT_BIT3) begin : g_bit3
      assign ne_bits = {28'd0, ob_has_entry, 3'd0};
   end else if (NE_MODE == NE_AT_BIT2) begin : g_bit2
      assign ne_bits = {29'd0, ob_has_entry, 2'd0};
   end else begin : g_both
      assign ne_bits = {28'd0, ob_has_entry, ob_has_entry, 2'd0};
   end

   assign isr = ne_bits | {31'd0, db_pending};
   assign irq = |(isr & ~imr);
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
   import cmdq_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DEPTH   = 16,
   parameter int NE_MODE = NE_AT_BIT3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              in_avail,
   output logic [31:0]       in_data,
   input  logic              in_pop,
   input  logic              out_push,
   input  logic [31:0]       out_data,
   output logic              out_full,
   output logic              cfg_pulse,
   input  logic              db_set,
   output logic              irq
);
   localparam int DW = 32;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("cmdq_regs: ADDR_W must cover offset 0xA0");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic          wr_inq, rd_outq, wr_db, wr_oclr, wr_imr;
   logic          in_full, in_empty;
   logic          ob_empty;
   logic [DW-1:0] ob_head;
   logic [DW-1:0] imr, isr, rmux;
   logic          db_pending, ovf_flag;

   assign wr_inq  = reg_wr && hit(reg_addr, OFS_INQ);
   assign wr_db   = reg_wr && hit(reg_addr, OFS_DOORBELL);
   assign wr_oclr = reg_wr && hit(reg_addr, OFS_OCLR);
   assign wr_imr  = reg_wr && hit(reg_addr, OFS_IMR);
   assign rd_outq = reg_rd && hit(reg_addr, OFS_OUTQ);

   cmdq_fifo #(.W(DW), .DEPTH(DEPTH)) u_inq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wr_inq),
      .push_data(reg_wdata),
      .pop      (in_pop),
      .head     (in_data),
      .full     (in_full),
      .empty    (in_empty)
   );
   assign in_avail = !in_empty;

   cmdq_fifo #(.W(DW), .DEPTH(DEPTH)) u_outq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (out_push),
      .push_data(out_data),
      .pop      (rd_outq),
      .head     (ob_head),
      .full     (out_full),
      .empty    (ob_empty)
   );

   cmdq_irq #(.NE_MODE(NE_MODE)) u_irq (
      .ob_has_entry(!ob_empty),
      .db_pending  (db_pending),
      .imr         (imr),
      .isr         (isr),
      .irq         (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr        <= '0;
         db_pending <= 1'b0;
         ovf_flag   <= 1'b0;
         cfg_pulse  <= 1'b0;
      end else begin
         if (wr_imr) imr <= reg_wdata;
         if (db_set)                       db_pending <= 1'b1;
         else if (wr_oclr && reg_wdata[0]) db_pending <= 1'b0;
         if (wr_inq && in_full) ovf_flag <= 1'b1;
         cfg_pulse <= wr_db && reg_wdata[0];
      end
   end

   always_comb begin
      rmux = '0;
      if      (hit(reg_addr, OFS_ISR))   rmux = isr;
      else if (hit(reg_addr, OFS_IMR))   rmux = imr;
      else if (hit(reg_addr, OFS_OUTQ))  rmux = ob_empty ? EMPTY_TAG : ob_head;
      else if (hit(reg_addr, OFS_OVF))   rmux = {31'd0, ovf_flag};
      else if (hit(reg_addr, OFS_OSTAT)) rmux = {31'd0, db_pending};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rmux;
   end
endmodule

// File: rtl/cmdq_regs_chk.sv
module cmdq_regs_chk
   import cmdq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              in_pop,
   input logic              out_push,
   input logic              cfg_pulse,
   input logic              db_set,
   input logic              irq,
   input logic              ob_empty,
   input logic              in_full,
   input logic              db_pending,
   input logic              ovf_flag
);
   a_r2_empty_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(OFS_OUTQ) && ob_empty) |=> reg_rdata == EMPTY_TAG);

   a_r2_empty_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(OFS_OUTQ) && ob_empty && !out_push) |=> ob_empty);

   a_r5_irq_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_empty && !db_pending) |-> !irq);

   a_r6_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pulse |-> $past(reg_wr && reg_addr == ADDR_W'(OFS_DOORBELL) && reg_wdata[0]));

   a_r7_clear_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_OCLR) && reg_wdata[0] && !db_set) |=> !db_pending);

   a_r7_set_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
      db_set |=> db_pending);

   a_r8_overflow_on_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_INQ) && in_full) |=> ovf_flag);

   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   a_r1_pop_not_blocking: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pop && in_full && !reg_wr) |=> !in_full);
endmodule

bind cmdq_regs cmdq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .in_pop    (in_pop),
   .out_push  (out_push),
   .cfg_pulse (cfg_pulse),
   .db_set    (db_set),
   .irq       (irq),
   .ob_empty  (ob_empty),
   .in_full   (in_full),
   .db_pending(db_pending),
   .ovf_flag  (ovf_flag)
);

// File: tb/sim_cmdq_regs.sv
module sim_cmdq_regs;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   // operation codes of the vector table
   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PUSH = 3'd2, OP_POPIN = 3'd3,
                          OP_DBSET = 3'd4, OP_IRQ = 3'd5, OP_AVAIL = 3'd6;

   typedef struct packed {
      logic [2:0]  op;
      logic [7:0]  addr;
      logic [31:0] data;  // write data, or expected value for checks
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 36;
   localparam vec_t VECS [NVEC] = '{
      '{OP_RD,    8'h44, 32'hFFFF_FFFF, 4'd2},  // R2 empty read
      '{OP_RD,    8'h30, 32'h0,         4'd10}, // R10 status after reset
      '{OP_IRQ,   8'h00, 32'h0,         4'd5},
      '{OP_PUSH,  8'h00, 32'h1000_0000, 4'd3},
      '{OP_PUSH,  8'h00, 32'h1000_0022, 4'd3},
      '{OP_RD,    8'h30, 32'h8,         4'd4},  // R4 bit 3 in default mode
      '{OP_IRQ,   8'h00, 32'h1,         4'd5},  // R5
      '{OP_WR,    8'h34, 32'h8,         4'd4},
      '{OP_RD,    8'h34, 32'h8,         4'd4},
      '{OP_IRQ,   8'h00, 32'h0,         4'd5},  // R5 masked
      '{OP_RD,    8'h30, 32'h8,         4'd4},
      '{OP_WR,    8'h34, 32'h0,         4'd4},
      '{OP_RD,    8'h44, 32'h1000_0000, 4'd2},
      '{OP_RD,    8'h44, 32'h1000_0022, 4'd3},  // R3 error flag kept
      '{OP_IRQ,   8'h00, 32'h0,         4'd5},
      '{OP_RD,    8'h44, 32'hFFFF_FFFF, 4'd2},
      '{OP_WR,    8'h40, 32'hABCD_0005, 4'd1},  // R1 low bits kept
      '{OP_WR,    8'h40, 32'h1234_0000, 4'd1},
      '{OP_POPIN, 8'h00, 32'hABCD_0005, 4'd1},
      '{OP_POPIN, 8'h00, 32'h1234_0000, 4'd1},
      '{OP_AVAIL, 8'h00, 32'h0,         4'd1},
      '{OP_DBSET, 8'h00, 32'h0,         4'd7},
      '{OP_RD,    8'h9C, 32'h1,         4'd7},  // R7
      '{OP_RD,    8'h30, 32'h1,         4'd4},
      '{OP_IRQ,   8'h00, 32'h1,         4'd5},
      '{OP_WR,    8'hA0, 32'h0,         4'd7},
      '{OP_RD,    8'h9C, 32'h1,         4'd7},
      '{OP_WR,    8'hA0, 32'h1,         4'd7},
      '{OP_RD,    8'h9C, 32'h0,         4'd7},
      '{OP_IRQ,   8'h00, 32'h0,         4'd5},
      '{OP_WR,    8'h60, 32'hFFFF_FFFF, 4'd9},  // R9 unmapped
      '{OP_RD,    8'h60, 32'h0,         4'd9},
      '{OP_WR,    8'h30, 32'h0000_000F, 4'd9},
      '{OP_RD,    8'h30, 32'h0,         4'd9},
      '{OP_RD,    8'h40, 32'h0,         4'd9},
      '{OP_RD,    8'h48, 32'h0,         4'd8}   // R8 no overflow yet
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_avail;
   logic [31:0] in_data;
   logic        in_pop = 1'b0;
   logic        out_push = 1'b0;
   logic [31:0] out_data = '0;
   logic        out_full, cfg_pulse;
   logic        db_set = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdq_regs #(.ADDR_W(8), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_avail(in_avail), .in_data(in_data),
      .in_pop(in_pop), .out_push(out_push), .out_data(out_data), .out_full(out_full),
      .cfg_pulse(cfg_pulse), .db_set(db_set), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic push(input logic [31:0] d);
      out_push = 1'b1; out_data = d;
      @(negedge clk);
      out_push = 1'b0;
   endtask

   task automatic popin(output logic [31:0] d);
      d = in_data;
      in_pop = 1'b1;
      @(negedge clk);
      in_pop = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      do_reset();

      // R10: outputs after reset
      check("R10 in_avail", {31'd0, in_avail}, 32'd0);
      check("R10 irq", {31'd0, irq}, 32'd0);
      check("R10 cfg_pulse", {31'd0, cfg_pulse}, 32'd0);
      check("R10 out_full", {31'd0, out_full}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         case (VECS[i].op)
            OP_WR:    wr(VECS[i].addr, VECS[i].data);
            OP_RD:    begin rd(VECS[i].addr, v); check(tag, v, VECS[i].data); end
            OP_PUSH:  push(VECS[i].data);
            OP_POPIN: begin popin(v); check(tag, v, VECS[i].data); end
            OP_DBSET: begin db_set = 1'b1; @(negedge clk); db_set = 1'b0; end
            OP_IRQ:   check(tag, {31'd0, irq}, VECS[i].data);
            OP_AVAIL: check(tag, {31'd0, in_avail}, VECS[i].data);
            default:  ;
         endcase
      end

      // R6: configuration pulse lasts one cycle, only for bit 0 set
      wr(8'h20, 32'h1);
      check("R6 pulse high", {31'd0, cfg_pulse}, 32'd1);
      @(negedge clk);
      check("R6 pulse one cycle", {31'd0, cfg_pulse}, 32'd0);
      wr(8'h20, 32'h2);
      check("R6 no pulse for bit0 clear", {31'd0, cfg_pulse}, 32'd0);

      // R5: irq falls in the cycle after the last pop
      push(32'h2000_0004);
      check("R5 irq up", {31'd0, irq}, 32'd1);
      rd(8'h44, v);
      check("R5 popped tag", v, 32'h2000_0004);
      check("R5 irq down after pop", {31'd0, irq}, 32'd0);

      // R7: set wins over a same-cycle clear
      db_set = 1'b1; reg_wr = 1'b1; reg_addr = 8'hA0; reg_wdata = 32'h1;
      @(negedge clk);
      db_set = 1'b0; reg_wr = 1'b0;
      rd(8'h9C, v);
      check("R7 set wins", v, 32'h1);
      wr(8'hA0, 32'h1);

      // R8: inbound overflow drops the write and sticks
      for (int i = 0; i <= DEPTH; i++) wr(8'h40, 32'h3000_0000 + 32'(i * 4));
      rd(8'h48, v);
      check("R8 overflow set", v, 32'h1);
      for (int i = 0; i < DEPTH; i++) begin
         popin(v);
         check("R8 order kept", v, 32'h3000_0000 + 32'(i * 4));
      end
      check("R8 extra entry dropped", {31'd0, in_avail}, 32'd0);
      rd(8'h48, v);
      check("R8 overflow sticky", v, 32'h1);

      // R11: outbound full and dropped push
      for (int i = 0; i < DEPTH; i++) push(32'h4000_0000 + 32'(i * 4));
      check("R11 out_full", {31'd0, out_full}, 32'd1);
      push(32'hDEAD_0000);
      for (int i = 0; i < DEPTH; i++) begin
         rd(8'h44, v);
         check("R11 drain order", v, 32'h4000_0000 + 32'(i * 4));
      end
      rd(8'h44, v);
      check("R11 push when full dropped", v, 32'hFFFF_FFFF);

      // R10: reset mid-run clears queues, mask, overflow, doorbell
      push(32'h5000_0000);
      wr(8'h40, 32'h5000_0004);
      wr(8'h34, 32'hFF);
      db_set = 1'b1; @(negedge clk); db_set = 1'b0;
      do_reset();
      rd(8'h34, v);
      check("R10 mask cleared", v, 32'h0);
      rd(8'h48, v);
      check("R10 overflow cleared", v, 32'h0);
      rd(8'h9C, v);
      check("R10 doorbell cleared", v, 32'h0);
      check("R10 inbound empty", {31'd0, in_avail}, 32'd0);
      rd(8'h44, v);
      check("R10 outbound empty", v, 32'hFFFF_FFFF);

      finish_run();
   end
endmodule